// File: doc/BRIEF.md
# Paired Instruction-Hash Control-Flow Monitor

This block watches the instruction stream of two processor cores and checks each retired instruction against a precomputed control-flow graph. Every graph row is one program state. It holds a 16-bit mask of the instruction hashes that may legally come next, and a base row number for the successors. A 32-bit instruction is folded into a 4-bit hash and expanded to one-hot form. The one-hot value is then matched against the mask of the row that the monitor currently points at. A hit moves the monitor to a successor row. A miss raises a recover pulse toward the core. The core is then expected to drop its packet and unwind its stack.

Both monitors read from a single graph memory with two read ports. The memory holds two graphs, one in each half. Each monitor takes a half-select bit when it is started, and that bit becomes the top address bit of every read that monitor makes. Two cores running the same program can therefore share one graph without loading it twice. A write port lets the controlling processor fill the memory while the monitors are idle. Monitoring begins with a start strobe. After a recover pulse the monitor returns to idle and waits for the next packet's start.

Top module: `cfmon_pair`

## Requirements
- R1: After reset, both monitors are idle with alarm low, active low and pointer 0.
- R2: A write on the load port stores `ld_data` at `ld_addr`. Address bit PTR_W picks the graph half and the low PTR_W bits pick the row. Within a row, data bits [15:0] hold the valid-hash mask and bits [PTR_W+15:16] hold the successor base.
- R3: The hash of an instruction is the XOR of its eight 4-bit nibbles, and hash value h stands for mask bit h. When bit h is set in the current row's mask, the pointer becomes base plus the number of set mask bits below bit h, taken modulo 2^PTR_W.
- R4: A monitor accepts a valid instruction on every clock. Each accepted instruction needs exactly one graph read, so back-to-back instructions never stall or raise a false alarm.
- R5: A valid instruction whose hash bit is clear in the current row's mask raises the alarm from the next cycle for exactly two cycles. After that the monitor is idle and the pointer is unchanged.
- R6: While the alarm is high, start strobes and instructions are ignored.
- R7: A start strobe outside an alarm sets the pointer to 0 and makes the monitor active from the next cycle. This applies whether the monitor was idle or already running.
- R8: While a monitor is idle, valid instructions change neither its pointer nor its alarm.
- R9: The two monitors run independently of each other. Both may select the same graph half, and fed the same instructions they follow identical pointers.
- R10: The half-select input is sampled only when a start is taken. Changing it while the monitor is running has no effect on the rows it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Graph write strobe |
| ld_addr | input | PTR_W+1 | Graph write address: half bit on top, then the row |
| ld_data | input | 16+PTR_W | Row contents: successor base on top, valid-hash mask below |
| mon_start | input | 2 | Start strobe, one bit per monitor |
| mon_gsel | input | 2 | Graph half select, one bit per monitor |
| ins_vld | input | 2 | Instruction-valid strobe, one bit per monitor |
| ins_word | input | 64 | Retired instructions, monitor 0 in bits [31:0] |
| mon_alarm | output | 2 | Recover request to each core |
| mon_active | output | 2 | Monitor is running |
| mon_ptr | output | 2*PTR_W | Current graph row of each monitor, monitor 0 in the low bits |

## Verification
A corrupted pointer or row register stays hidden at first, but it reaches the ports within one cycle in two ways: the exposed pointer differs from the bench model, and the next legal instruction draws a false recover pulse. An error in the rank arithmetic appears only after a branch row, so the bench walks rows with several mask bits set and picks a different successor each time. Faults in the recover counter show up as an alarm that lasts the wrong length, or as a start that gets through during an alarm. The bench compares pointer, alarm and active for both monitors on every clock.

// File: rtl/cfmon_pair.sv
module cfmon_pair #(
  parameter int PTR_W       = 10,
  parameter int INSTR_W     = 32,
  parameter int HASH_W      = 4,
  parameter int RECOVER_CYC = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_we,
  input  logic [PTR_W:0]               ld_addr,
  input  logic [(1<<HASH_W)+PTR_W-1:0] ld_data,
  input  logic [1:0]                   mon_start,
  input  logic [1:0]                   mon_gsel,
  input  logic [1:0]                   ins_vld,
  input  logic [2*INSTR_W-1:0]         ins_word,
  output logic [1:0]                   mon_alarm,
  output logic [1:0]                   mon_active,
  output logic [2*PTR_W-1:0]           mon_ptr
);
  localparam int HV    = 1 << HASH_W;
  localparam int EW    = HV + PTR_W;
  localparam int DEPTH = 1 << (PTR_W + 1);
  localparam int NIB   = INSTR_W / HASH_W;
  localparam int RK_W  = $clog2(HV + 1);
  localparam int RC_W  = $clog2(RECOVER_CYC + 1);

  logic [EW-1:0] gmem [DEPTH];

  always_ff @(posedge clk)
    if (ld_we) gmem[ld_addr] <= ld_data;

  for (genvar g = 0; g < 2; g++) begin : g_mon
    logic [INSTR_W-1:0] word;
    logic [HASH_W-1:0]  hash;
    logic [HV-1:0]      onehot, mask;
    logic [PTR_W-1:0]   base, nxt, ptr_q, rd_row;
    logic [RK_W-1:0]    rank;
    logic [EW-1:0]      ent_q;
    logic [RC_W-1:0]    rec_q;
    logic               run_q, half_q, rd_half;
    logic               quiet, take_start, step, hit, rd_en;

    assign word = ins_word[g*INSTR_W +: INSTR_W];

    always_comb begin
      hash = '0;
      for (int n = 0; n < NIB; n++) hash ^= word[n*HASH_W +: HASH_W];
    end

    assign onehot = HV'(1) << hash;
    assign mask   = ent_q[HV-1:0];
    assign base   = ent_q[EW-1:HV];
    assign hit    = |(onehot & mask);

    always_comb begin
      rank = '0;
      for (int b = 0; b < HV; b++)
        if (mask[b] && (HASH_W'(b) < hash)) rank = rank + RK_W'(1);
    end

    assign nxt        = base + PTR_W'(rank);
    assign quiet      = (rec_q == '0);
    assign take_start = quiet && mon_start[g];
    assign step       = quiet && !mon_start[g] && run_q && ins_vld[g];
    assign rd_en      = take_start || (step && hit);
    assign rd_row     = take_start ? '0 : nxt;
    assign rd_half    = take_start ? mon_gsel[g] : half_q;

    always_ff @(posedge clk)
      if (rd_en) ent_q <= gmem[{rd_half, rd_row}];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q  <= 1'b0;
        rec_q  <= '0;
        ptr_q  <= '0;
        half_q <= 1'b0;
      end else if (!quiet) begin
        rec_q <= rec_q - RC_W'(1);
      end else if (take_start) begin
        run_q  <= 1'b1;
        ptr_q  <= '0;
        half_q <= mon_gsel[g];
      end else if (step) begin
        if (hit) ptr_q <= nxt;
        else begin
          run_q <= 1'b0;
          rec_q <= RC_W'(RECOVER_CYC);
        end
      end
    end

    assign mon_alarm[g]                = !quiet;
    assign mon_active[g]               = run_q;
    assign mon_ptr[g*PTR_W +: PTR_W]   = ptr_q;

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_start[g] && !mon_alarm[g]) |=> (mon_active[g] && mon_ptr[g*PTR_W +: PTR_W] == '0)); // R7
    AST_MISS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_active[g] && ins_vld[g] && !mon_start[g] && !hit) |=> mon_alarm[g]); // R5
    AST_ALARM_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mon_alarm[g]) |-> !mon_active[g]); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_active[g] && !mon_alarm[g] && !mon_start[g]) |=>
        ($stable(mon_ptr[g*PTR_W +: PTR_W]) && !mon_alarm[g])); // R8
    AST_HIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_active[g] && ins_vld[g] && hit && !mon_alarm[g]) |=> mon_active[g]); // R4
  end
endmodule

// File: tb/cfmon_pair_tb.sv
module cfmon_pair_tb;
  localparam int PTR_W = 10;
  localparam int EW    = 16 + PTR_W;
  localparam int DEPTH = 1 << (PTR_W + 1);

  logic clk = 0, rst_n = 0;
  logic ld_we = 0;
  logic [PTR_W:0] ld_addr = '0;
  logic [EW-1:0] ld_data = '0;
  logic [1:0] st = '0, gs = '0, iv = '0;
  logic [63:0] iw = '0;
  logic [1:0] alarm, active;
  logic [2*PTR_W-1:0] ptr;

  always #4 clk = ~clk;

  cfmon_pair #(.PTR_W(PTR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .mon_start(st), .mon_gsel(gs), .ins_vld(iv), .ins_word(iw),
    .mon_alarm(alarm), .mon_active(active), .mon_ptr(ptr));

  logic [EW-1:0] bm [DEPTH];
  int m_ptr [2];
  int m_half [2];
  int m_run [2];
  int m_rec [2];
  int checks = 0, fails = 0;
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    rs = rs * 32'd1664525 + 32'd1013904223;
    return rs;
  endfunction

  function automatic logic [3:0] fold(input logic [31:0] w);
    logic [3:0] h = 0;
    for (int n = 0; n < 8; n++) h ^= w[n*4 +: 4];
    return h;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] h, input logic [31:0] r);
    logic [31:0] w = {r[31:4], 4'h0};
    w[3:0] = h ^ fold(w);
    return w;
  endfunction

  function automatic logic [15:0] cur_mask(input int i);
    logic [EW-1:0] e = bm[m_half[i]*(1<<PTR_W) + m_ptr[i]];
    return e[15:0];
  endfunction

  function automatic logic [3:0] good_h(input int i, input int k);
    logic [15:0] m = cur_mask(i);
    int cnt = 0;
    for (int b = 0; b < 16; b++) if (m[b]) cnt++;
    if (cnt == 0) return 4'd0;
    k = k % cnt;
    for (int b = 0; b < 16; b++) if (m[b]) begin
      if (k == 0) return 4'(b);
      k--;
    end
    return 4'd0;
  endfunction

  function automatic logic [3:0] bad_h(input int i, input int off);
    logic [15:0] m = cur_mask(i);
    for (int b = 0; b < 16; b++) if (!m[(b+off)%16]) return 4'((b+off)%16);
    return 4'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      if (m_rec[i] != 0) m_rec[i]--;
      else if (st[i]) begin
        m_run[i] = 1; m_ptr[i] = 0; m_half[i] = gs[i];
      end else if (m_run[i] && iv[i]) begin
        logic [EW-1:0] e = bm[m_half[i]*(1<<PTR_W) + m_ptr[i]];
        logic [3:0] h = fold(iw[i*32 +: 32]);
        if (e[h]) begin
          int rk = 0;
          for (int b = 0; b < h; b++) if (e[b]) rk++;
          m_ptr[i] = (int'(e[EW-1:16]) + rk) % (1 << PTR_W);
        end else begin
          m_run[i] = 0; m_rec[i] = 2;
        end
      end
    end
    if (ld_we) bm[ld_addr] = ld_data;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check($sformatf("R3 ptr%0d", i), int'(ptr[i*PTR_W +: PTR_W]), m_ptr[i]);
      check($sformatf("R5 alarm%0d", i), int'(alarm[i]), int'(m_rec[i] != 0));
      check($sformatf("R7 active%0d", i), int'(active[i]), m_run[i]);
    end
  endtask

  task automatic feed(input int i, input logic good, input int k);
    logic [3:0] h = good ? good_h(i, k) : bad_h(i, k);
    iv[i] = 1'b1;
    iw[i*32 +: 32] = mk(h, rnd());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_ptr[i] = 0; m_half[i] = 0; m_run[i] = 0; m_rec[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 alarm", int'(alarm), 0);
    check("R1 active", int'(active), 0);
    check("R1 ptr", int'(ptr), 0);
    rst_n = 1;

    for (int a = 0; a < DEPTH; a++) begin
      logic [31:0] r = rnd();
      logic [15:0] m = r[15:0] & 16'h7FFF;
      if (a % 61 == 7) m = '0;
      ld_we = 1; ld_addr = (PTR_W+1)'(a);
      ld_data = {PTR_W'(rnd() % (1 << PTR_W)), m};
      tick();
    end
    ld_we = 1; ld_addr = '0; ld_data = {PTR_W'(77), 16'h0008};
    tick();
    ld_we = 0;

    st = 2'b01; gs = 2'b00; tick();
    st = 2'b00; iv = 2'b01; iw[31:0] = mk(4'd3, 32'hDEAD_BEE0); tick();
    check("R2 loaded row", int'(ptr[PTR_W-1:0]), 77);

    for (int c = 0; c < 20; c++) begin
      iv = 2'b00;
      if (m_run[0]) feed(0, 1'b1, c);
      tick();
    end
    check("R4 no false alarm", int'(alarm[0]), 0);
    check("R4 still active", int'(active[0]), m_run[0]);

    iv = 2'b00; st = 2'b11; gs = 2'b11; tick();
    st = 2'b00;
    for (int c = 0; c < 12; c++) begin
      iv = 2'b00;
      gs = 2'(c);
      if (m_run[0]) begin
        feed(0, 1'b1, c + 1);
        iv[1] = 1'b1; iw[63:32] = iw[31:0];
      end
      tick();
      check("R9 shared half", int'(ptr[2*PTR_W-1:PTR_W]), int'(ptr[PTR_W-1:0]));
      check("R10 latched half", int'(ptr[PTR_W-1:0]), m_ptr[0]);
    end

    iv = 2'b00; st = 2'b01; tick();
    st = 2'b00; feed(0, 1'b0, 5); tick();
    check("R5 alarm raised", int'(alarm[0]), 1);
    st = 2'b01; feed(0, 1'b1, 0); tick();
    check("R6 alarm holds", int'(alarm[0]), 1);
    tick();
    st = 2'b00; iv = 2'b00;
    check("R6 start ignored", int'(active[0]), 0);
    check("R5 alarm length", int'(alarm[0]), 0);

    begin
      int held = int'(ptr[PTR_W-1:0]);
      for (int c = 0; c < 3; c++) begin
        feed(0, 1'b1, c); tick();
      end
      check("R8 idle ptr", int'(ptr[PTR_W-1:0]), held);
      check("R8 idle alarm", int'(alarm[0]), 0);
    end

    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < 2; i++) begin
        logic [31:0] r = rnd();
        st[i] = (r[7:0] % 100) < 3;
        gs[i] = r[8];
        iv[i] = 1'b0;
        if ((r[19:12] % 100) < 65) feed(i, (r[27:20] % 100) >= 7, int'(r[31:28]));
      end
      tick();
    end
    summary();
  end
endmodule